// File: doc/BRIEF.md
# Serial Flash Boot Fetcher

This block loads a configuration stream from an external serial flash with no help from software. A dedicated configuration reset, active low, restarts it; the reset counts only when it is held low for a minimum number of clock cycles, and shorter dips are treated as noise. While that reset is held, a three-bit strap input is latched. If the latched code selects one of the two master-serial modes, the block waits a fixed start delay after the reset rises. It then selects the flash, sends a read opcode with a zero address and keeps the serial clock running to pull in data.

Incoming bits are gathered into bytes with the most significant bit first. Four bytes form a 32-bit word, with the first byte received as the least significant. Words leave on a valid/ready stream. A word stays on `word_data` with `word_valid` high until the sink takes it with `word_ready`. If the next word is complete before the sink has taken the current one, the serial clock pauses, so nothing is lost. The first word must be the sync pattern 0x12345678; any other value gives a one-cycle error pulse and stops the fetch.

The fetch ends when the programmed number of words has been accepted, or when the sink raises `sink_done`. Once the fetch is complete, the flash pins are parked (select high, clock low, data out low) and `cfg_ready` is raised.

Top module: `spi_boot_fetch`

## Requirements
- R1: A low level on `rst_cfg_n` restarts the block only after it has lasted RST_MIN_CYC clock cycles; a shorter low pulse changes neither `cfg_ready` nor the flash pins, and no new flash session follows it.
- R2: The strap code is latched while the qualified reset is held. Codes 3'b000 and 3'b001 start a fetch. Every other code leaves the block idle: `spi_cs_n` stays high, no words are sent and `cfg_ready` stays low.
- R3: A change of `mode_strap` after `rst_cfg_n` has risen has no effect until the next qualified reset.
- R4: `spi_cs_n` falls no earlier than START_DLY_CYC and no later than START_DLY_CYC+3 clock cycles after `rst_cfg_n` rises.
- R5: The first 32 bits on `spi_mosi`, taken at rising edges of `spi_sck`, are 0x03 and then a 24-bit zero address, most significant bit first. `spi_sck` runs at the clock rate divided by CLK_DIV.
- R6: `spi_miso` is sampled on rising `spi_sck` edges. Each byte is received most significant bit first. Each word is built with its first received byte in bits 7:0 and its fourth received byte in bits 31:24.
- R7: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` holds its value. The serial clock stalls rather than dropping or repeating a word.
- R8: When `word_limit` is non-zero, the fetch ends as soon as that many words have been accepted. A limit of zero means no word count applies.
- R9: `sink_done` ends the fetch at once. A word not yet accepted is discarded.
- R10: After the fetch ends, `cfg_ready` is high, `spi_cs_n` is high, `spi_sck` and `spi_mosi` are low, and `word_valid` is low, until the next qualified reset.
- R11: If the first word is not 0x12345678, `cfg_error` is high for exactly one cycle. That word is not delivered, the pins park, and `cfg_ready` stays low.
- R12: After `rst_n`, `cfg_ready`, `cfg_error` and `word_valid` are low and `spi_cs_n` is high. No session starts until a qualified configuration reset has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| rst_cfg_n | input | 1 | Configuration reset, active low, length-qualified |
| mode_strap | input | 3 | Mode strap code |
| word_limit | input | CNT_W | Number of words to fetch; 0 means no limit |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_sck | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| word_data | output | WORD_W | Assembled word |
| word_valid | output | 1 | Word available |
| word_ready | input | 1 | Sink accepts the word |
| sink_done | input | 1 | Sink requests the end of the fetch |
| cfg_ready | output | 1 | Fetch complete |
| cfg_error | output | 1 | One-cycle pulse on a bad sync word |

## Verification
The fetch is run under three sink behaviours: always ready, ready one cycle in three, and ready so rarely that every word stalls the serial clock. Comparing the delivered words across these cases separates a correct stall from a dropped or repeated word. Flash words with distinct bytes reveal any reversal of bit or byte order. A bad sync word, non-master strap codes, short reset pulses and strap changes after release each test a rule that the normal path never reaches.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [2:0] {
    ST_HOLD, ST_IDLE, ST_DELAY, ST_CMD, ST_DATA, ST_DONE, ST_FAULT
  } fetch_state_e;

  localparam logic [31:0] SYNC_WORD = 32'h1234_5678;
  localparam logic [7:0]  RD_OPCODE = 8'h03;
  localparam int          CMD_BITS  = 32;

  // Codes 000 and 001 are the two master-serial modes.
  function automatic logic is_master_mode(input logic [2:0] m);
    return (m[2:1] == 2'b00);
  endfunction
endpackage

// File: rtl/spi_boot_rstqual.sv
module spi_boot_rstqual #(
  parameter int MIN_LOW = 375,
  parameter int MODE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_cfg_n,
  input  logic [MODE_W-1:0] strap_i,
  input  logic              consume_i,
  output logic              long_low_o,
  output logic              armed_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int CW = $clog2(MIN_LOW + 1);

  logic [CW-1:0] low_cnt;

  assign long_low_o = (low_cnt == CW'(MIN_LOW));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      armed_o <= 1'b0;
      mode_o  <= '0;
    end else begin
      if (rst_cfg_n)                     low_cnt <= '0;
      else if (low_cnt != CW'(MIN_LOW))  low_cnt <= low_cnt + CW'(1);
      if (long_low_o)      armed_o <= 1'b1;
      else if (consume_i)  armed_o <= 1'b0;
      if (long_low_o && !rst_cfg_n) mode_o <= strap_i;
    end
  end
endmodule

// File: rtl/spi_boot_sclk.sv
module spi_boot_sclk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic sck_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;

  logic [HW-1:0] hcnt;
  logic          tick;

  assign tick   = run_i && (hcnt == HW'(HALF - 1));
  assign rise_o = tick && !sck_o;
  assign fall_o = tick && sck_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      sck_o <= 1'b0;
    end else if (!run_i) begin
      hcnt  <= '0;
      sck_o <= 1'b0;
    end else if (tick) begin
      hcnt  <= '0;
      sck_o <= ~sck_o;
    end else begin
      hcnt  <= hcnt + HW'(1);
    end
  end
endmodule

// File: rtl/spi_boot_shiftin.sv
module spi_boot_shiftin #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic [WORD_W-1:0] acc_o,
  output logic              done_o
);
  localparam int BW = $clog2(WORD_W);

  logic [6:0]    byte_sr;
  logic [BW-1:0] bcnt;
  logic [7:0]    nbyte;
  logic          byte_end;

  assign nbyte    = {byte_sr, bit_i};
  assign byte_end = (bcnt[2:0] == 3'd7);
  // New byte enters at the top, earlier bytes move down: first byte ends in [7:0].
  assign word_o   = {nbyte, acc_o[WORD_W-1:8]};
  assign done_o   = sample_i && (bcnt == BW'(WORD_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_sr <= '0;
      bcnt    <= '0;
      acc_o   <= '0;
    end else if (clr_i) begin
      byte_sr <= '0;
      bcnt    <= '0;
    end else if (sample_i) begin
      byte_sr <= nbyte[6:0];
      bcnt    <= done_o ? '0 : bcnt + BW'(1);
      if (byte_end) acc_o <= word_o;
    end
  end
endmodule

// File: rtl/spi_boot_fetch.sv
module spi_boot_fetch
  import spi_boot_pkg::*;
#(
  parameter int CLK_DIV       = 4,
  parameter int RST_MIN_CYC   = 375,
  parameter int START_DLY_CYC = 64,
  parameter int WORD_W        = 32,
  parameter int CNT_W         = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_cfg_n,
  input  logic [2:0]        mode_strap,
  input  logic [CNT_W-1:0]  word_limit,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  input  logic              word_ready,
  input  logic              sink_done,
  output logic              cfg_ready,
  output logic              cfg_error
);
  localparam int DW = $clog2(START_DLY_CYC + 1);
  localparam int KW = $clog2(CMD_BITS);

  fetch_state_e      st;
  logic              long_low, armed, consume;
  logic [2:0]        mode_q;
  logic              sck_q, rise, fall, run, session;
  logic [CMD_BITS-1:0] cmd_sr;
  logic [KW-1:0]     cmd_cnt;
  logic [DW-1:0]     dly_cnt;
  logic [WORD_W-1:0] out_q, w_full, w_acc;
  logic              out_v, pend, got_first, w_done, err_q;
  logic [CNT_W-1:0]  acc_cnt;
  logic              take, slot_free, last_take;

  assign session   = (st == ST_CMD) || (st == ST_DATA);
  assign run       = session && !(pend && !sck_q);
  assign consume   = (st == ST_HOLD) && rst_cfg_n && armed && !long_low;
  assign take      = out_v && word_ready;
  assign slot_free = !out_v || take;
  assign last_take = take && (word_limit != '0) && ((acc_cnt + CNT_W'(1)) == word_limit);

  spi_boot_rstqual #(.MIN_LOW(RST_MIN_CYC), .MODE_W(3)) u_qual (
    .clk(clk), .rst_n(rst_n), .rst_cfg_n(rst_cfg_n), .strap_i(mode_strap),
    .consume_i(consume), .long_low_o(long_low), .armed_o(armed), .mode_o(mode_q)
  );

  spi_boot_sclk #(.DIV(CLK_DIV)) u_sclk (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .sck_o(sck_q), .rise_o(rise), .fall_o(fall)
  );

  spi_boot_shiftin #(.WORD_W(WORD_W)) u_shin (
    .clk(clk), .rst_n(rst_n), .clr_i(st != ST_DATA),
    .sample_i(rise && (st == ST_DATA)), .bit_i(spi_miso),
    .word_o(w_full), .acc_o(w_acc), .done_o(w_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_HOLD;
      dly_cnt   <= '0;
      cmd_sr    <= '0;
      cmd_cnt   <= '0;
      out_q     <= '0;
      out_v     <= 1'b0;
      pend      <= 1'b0;
      got_first <= 1'b0;
      acc_cnt   <= '0;
      err_q     <= 1'b0;
    end else if (long_low) begin
      st    <= ST_HOLD;
      out_v <= 1'b0;
      pend  <= 1'b0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (st)
        ST_HOLD: if (consume) begin
          st      <= is_master_mode(mode_q) ? ST_DELAY : ST_IDLE;
          dly_cnt <= '0;
        end
        ST_DELAY: begin
          if (dly_cnt == DW'(START_DLY_CYC - 1)) begin
            st      <= ST_CMD;
            cmd_sr  <= {RD_OPCODE, {(CMD_BITS-8){1'b0}}};
            cmd_cnt <= '0;
          end else begin
            dly_cnt <= dly_cnt + DW'(1);
          end
        end
        ST_CMD: begin
          if (sink_done) begin
            st <= ST_DONE;
          end else begin
            if (fall) cmd_sr <= cmd_sr << 1;
            if (rise) begin
              if (cmd_cnt == KW'(CMD_BITS - 1)) begin
                st        <= ST_DATA;
                got_first <= 1'b0;
                acc_cnt   <= '0;
              end else begin
                cmd_cnt <= cmd_cnt + KW'(1);
              end
            end
          end
        end
        ST_DATA: begin
          if (sink_done || last_take) begin
            st    <= ST_DONE;
            out_v <= 1'b0;
            pend  <= 1'b0;
          end else if (w_done && !got_first && (w_full != WORD_W'(SYNC_WORD))) begin
            st    <= ST_FAULT;
            err_q <= 1'b1;
            out_v <= 1'b0;
          end else begin
            if (take) acc_cnt <= acc_cnt + CNT_W'(1);
            if (w_done) begin
              got_first <= 1'b1;
              if (slot_free) begin
                out_q <= w_full;
                out_v <= 1'b1;
              end else begin
                pend  <= 1'b1;
              end
            end else if (pend && slot_free) begin
              out_q <= w_acc;
              out_v <= 1'b1;
              pend  <= 1'b0;
            end else if (take) begin
              out_v <= 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign spi_cs_n   = !session;
  assign spi_sck    = sck_q && session;
  assign spi_mosi   = (st == ST_CMD) && cmd_sr[CMD_BITS-1];
  assign word_data  = out_q;
  assign word_valid = out_v;
  assign cfg_ready  = (st == ST_DONE);
  assign cfg_error  = err_q;
endmodule

// File: rtl/spi_boot_fetch_chk.sv
module spi_boot_fetch_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rst_cfg_n,
  input logic              spi_cs_n,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic [WORD_W-1:0] word_data,
  input logic              word_valid,
  input logic              word_ready,
  input logic              sink_done,
  input logic              cfg_ready,
  input logic              cfg_error
);
  // R7: a held word stays put until taken
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !word_ready && rst_cfg_n && !sink_done) |=> (word_valid && $stable(word_data)));

  // R10: parked pins once complete
  a_r10_park: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |-> (spi_cs_n && !spi_sck && !spi_mosi && !word_valid));

  // R11: error is a single-cycle pulse
  a_r11_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |=> !cfg_error);

  // R11: error never coincides with completion
  a_r11_err_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !cfg_ready);

  // R1: completion survives while the configuration reset is high
  a_r1_short_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ready && rst_cfg_n) |=> cfg_ready);
endmodule

bind spi_boot_fetch spi_boot_fetch_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_cfg_n(rst_cfg_n), .spi_cs_n(spi_cs_n),
  .spi_sck(spi_sck), .spi_mosi(spi_mosi), .word_data(word_data),
  .word_valid(word_valid), .word_ready(word_ready), .sink_done(sink_done),
  .cfg_ready(cfg_ready), .cfg_error(cfg_error)
);

// File: tb/spi_boot_fetch_test.sv
module spi_boot_fetch_test;
  localparam int RMIN = 375;
  localparam int SDLY = 64;
  localparam int DIV  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_cfg_n = 1'b1;
  logic [2:0]  mode_strap = 3'b000;
  logic [15:0] word_limit = 16'd0;
  logic        spi_cs_n, spi_sck, spi_mosi;
  logic        spi_miso;
  logic [31:0] word_data;
  logic        word_valid;
  logic        word_ready;
  logic        sink_done = 1'b0;
  logic        cfg_ready, cfg_error;

  always #4 clk = ~clk;

  spi_boot_fetch #(.CLK_DIV(DIV), .RST_MIN_CYC(RMIN), .START_DLY_CYC(SDLY)) uut (
    .clk(clk), .rst_n(rst_n), .rst_cfg_n(rst_cfg_n), .mode_strap(mode_strap),
    .word_limit(word_limit), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .word_data(word_data),
    .word_valid(word_valid), .word_ready(word_ready), .sink_done(sink_done),
    .cfg_ready(cfg_ready), .cfg_error(cfg_error)
  );

  int n_chk = 0;
  int n_bad = 0;
  int pat = 0;
  logic bad_sync = 1'b0;

  function automatic logic [31:0] flash_word(input int i, input logic bad);
    if (i == 0) return bad ? 32'hDEAD_BEEF : 32'h1234_5678;
    return 32'hA500_0000 ^ (i * 32'h0103_0507);
  endfunction

  // Flash model: counts rising SCK edges, answers after the 32-bit command.
  int rc = 0;
  int sess_n = 0;
  logic [31:0] cmd_rx = '0;
  logic prev_cs = 1'b1, prev_sck = 1'b0;
  always @(spi_cs_n, spi_sck) begin
    if (prev_cs && !spi_cs_n) begin
      sess_n++;
      rc = 0;
      cmd_rx = '0;
    end
    if (!spi_cs_n && !prev_sck && spi_sck) begin
      if (rc < 32) cmd_rx = {cmd_rx[30:0], spi_mosi};
      rc++;
    end
    if (!spi_cs_n && prev_sck && !spi_sck && rc >= 32) begin
      int n;
      logic [31:0] w;
      n = rc - 32;
      w = flash_word(n / 32, bad_sync);
      spi_miso = w[8 * ((n / 8) % 4) + 7 - (n % 8)];
    end
    prev_cs = spi_cs_n;
    prev_sck = spi_sck;
  end

  // Sink: sets ready for the next edge and logs the handshake it implies.
  int cyc = 0;
  int rec_n = 0;
  int err_n = 0;
  int stab_bad = 0;
  logic [31:0] rec [256];
  logic prev_hold = 1'b0;
  logic [31:0] prev_data = '0;
  always @(negedge clk) begin
    logic r;
    cyc++;
    if (prev_hold && (!word_valid || word_data !== prev_data)) stab_bad++;
    case (pat)
      0: r = 1'b1;
      1: r = (cyc % 3 == 0);
      default: r = (cyc % 150 == 0);
    endcase
    word_ready = r;
    if (word_valid && r) begin
      if (rec_n < 256) rec[rec_n] = word_data;
      rec_n++;
    end
    if (cfg_error) err_n++;
    prev_hold = word_valid && !r && rst_cfg_n && !sink_done;
    prev_data = word_data;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic qual_reset(input logic [2:0] m);
    @(negedge clk);
    mode_strap = m;
    rst_cfg_n = 1'b0;
    repeat (RMIN + 5) @(negedge clk);
    rst_cfg_n = 1'b1;
  endtask

  // {mode, limit, ready pattern, bad sync, expected words, expected ready, expected error}
  localparam logic [23:0] VEC [8] = '{
    {3'd0, 8'd4, 2'd0, 1'b0, 8'd4, 1'b1, 1'b0},
    {3'd1, 8'd3, 2'd1, 1'b0, 8'd3, 1'b1, 1'b0},
    {3'd0, 8'd5, 2'd2, 1'b0, 8'd5, 1'b1, 1'b0},
    {3'd0, 8'd2, 2'd0, 1'b1, 8'd0, 1'b0, 1'b1},
    {3'd2, 8'd3, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0},
    {3'd4, 8'd3, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0},
    {3'd0, 8'd1, 2'd1, 1'b0, 8'd1, 1'b1, 1'b0},
    {3'd7, 8'd2, 2'd0, 1'b0, 8'd0, 1'b0, 1'b0}
  };

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int rb, sb, eb, k, w;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset pins", {31'd0, spi_cs_n}, 32'd1);
    chk("R12 reset flags", {29'd0, cfg_ready, cfg_error, word_valid}, 32'd0);
    rst_n = 1'b1;
    repeat (500) @(negedge clk);
    chk("R12 no session before qualified reset", sess_n, 0);

    for (int v = 0; v < 8; v++) begin
      logic [2:0] m;
      logic [7:0] ew;
      m = VEC[v][23:21];
      word_limit = {8'd0, VEC[v][20:13]};
      pat = int'(VEC[v][12:11]);
      bad_sync = VEC[v][10];
      ew = VEC[v][9:2];
      rb = rec_n; sb = sess_n; eb = err_n;
      qual_reset(m);
      k = 0;
      while (!cfg_ready && err_n == eb && k < 5000) begin @(negedge clk); k++; end
      repeat (300) @(negedge clk);
      chk("R8 word count", rec_n - rb, {24'd0, ew});
      w = 0;
      for (int i = 0; i < int'(ew); i++) if (rec[rb + i] !== flash_word(i, bad_sync)) w++;
      chk("R6 word values", w, 0);
      chk("R10 ready level", {31'd0, cfg_ready}, {31'd0, VEC[v][1]});
      chk("R11 error pulses", err_n - eb, {31'd0, VEC[v][0]});
      chk("R10 parked pins", {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'd4);
      if (m[2:1] == 2'b00) chk("R5 read command", cmd_rx, 32'h0300_0000);
      else chk("R2 idle for non-master code", sess_n - sb, 0);
    end
    chk("R7 held word stable", stab_bad, 0);

    // R4 start delay; R3 strap change after release
    word_limit = 16'd2; pat = 0; bad_sync = 1'b0;
    sb = sess_n;
    qual_reset(3'b000);
    mode_strap = 3'b010;
    k = 0;
    while (spi_cs_n && k < 2000) begin @(negedge clk); k++; end
    chk("R4 start delay window", {31'd0, (k >= SDLY && k <= SDLY + 3)}, 32'd1);
    k = 0;
    while (!cfg_ready && k < 3000) begin @(negedge clk); k++; end
    chk("R3 strap change ignored, fetch done", {31'd0, cfg_ready}, 32'd1);

    // R1 short pulse ignored
    sb = sess_n;
    rst_cfg_n = 1'b0;
    repeat (100) @(negedge clk);
    rst_cfg_n = 1'b1;
    repeat (400) @(negedge clk);
    chk("R1 short pulse keeps ready", {31'd0, cfg_ready}, 32'd1);
    chk("R1 short pulse no session", sess_n - sb, 0);

    // R1 long pulse restarts; R3 strap raised to master after release ignored
    @(negedge clk);
    mode_strap = 3'b010;
    rst_cfg_n = 1'b0;
    repeat (RMIN + 5) @(negedge clk);
    chk("R1 long pulse clears ready", {31'd0, cfg_ready}, 32'd0);
    rst_cfg_n = 1'b1;
    @(negedge clk);
    mode_strap = 3'b000;
    repeat (1500) @(negedge clk);
    chk("R3 late strap leaves idle", sess_n - sb, 0);
    chk("R2 idle ready low", {31'd0, cfg_ready}, 32'd0);

    // R9 sink_done with no word limit
    word_limit = 16'd0; pat = 0;
    rb = rec_n;
    qual_reset(3'b000);
    k = 0;
    while (rec_n - rb < 3 && k < 4000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
    sink_done = 1'b1;
    @(negedge clk);
    sink_done = 1'b0;
    chk("R9 sink_done completes", {31'd0, cfg_ready}, 32'd1);
    repeat (400) @(negedge clk);
    chk("R9 no words after sink_done", rec_n - rb, 3);
    chk("R10 parked after sink_done", {29'd0, spi_cs_n, spi_sck, spi_mosi}, 32'd4);

    finish_run();
  end
endmodule